// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns a stream of 32-bit audio words into a standard I2S output: a bit clock, a word-select line and serial data, all generated from the master clock (MCLK) domain. The block is always bit-clock and frame master, with non-inverted polarities. A transmit FIFO outside the block holds the words in pairs, left then right. The FIFO's head word and empty flag are visible at all times, and the block pops one word at the start of each channel slot.

The bit clock is derived from MCLK through an 8-bit divide setting. The number of bits per channel slot comes from a 6-bit resolution setting, and only the low bits of each FIFO word are shifted out, MSB first. Each time transmit is switched on, one frame of silence goes out first. If the FIFO runs dry, the affected slot carries zeros and an underrun pulse is raised. When transmit is switched off, the frame in progress is completed and the lines then rest low.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The bit clock toggles every `ratio + 2` MCLK cycles, so one full bit-clock period is `2*(ratio+2)` MCLK cycles.
- R2: The slot length is `res` bits when `res` is between 1 and 32. A value of 0 or any value above 32 gives 32-bit slots. Each slot carries bits `res-1` down to 0 of its FIFO word, MSB first, and the higher word bits are never sent.
- R3: Every data frame pops exactly two FIFO words: the left word at the start of the left slot (word select low) and the right word at the start of the right slot (word select high). Every pop happens in the MCLK cycle in which the bit clock falls.
- R4: Word select changes together with the last bit (LSB) of the preceding slot, one bit clock ahead of the next slot's MSB. Every slot in a run is therefore exactly the slot length in bits.
- R5: Serial data and word select change only on MCLK edges at which the bit clock falls.
- R6: On each 0-to-1 change of `tx_en` (including `tx_en` already high when reset is released), the next frame sends zeros in both slots, left first, and pops nothing. Queued data follows in the frame after it.
- R7: If the FIFO is empty when a slot needs a word, that slot sends zeros, nothing is popped, and `underrun` is high for exactly one MCLK cycle.
- R8: When `tx_en` is cleared, the frame in progress is completed (both slots), after which word select and serial data stay low and nothing more is popped.
- R9: During reset, `bclk`, `ws`, `sd`, `fifo_pop` and `underrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MCLK, the only clock of the block |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Bit-clock divide setting |
| res | input | 6 | Sample resolution in bits per slot |
| fifo_data | input | 32 | Head word of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this clock edge |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low for left, high for right |
| sd | output | 1 | Serial data, MSB first |
| underrun | output | 1 | One-cycle pulse when a slot found the FIFO empty |

## Verification
A wrong bit index or slot counter shows up at the ports within one slot. Word select then moves at a bit count other than the resolution, and the decoded word no longer matches the FIFO word pushed for that slot. A lost or stuck silence flag appears in the first frame after enable, as a non-zero decoded word or a pop within the first frame time. A divider error changes the measured bit-clock period at the next rising edge. A mishandled disable leaves an odd number of slots or non-quiet lines within two frame times.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

   // Channel slot order within one frame: left is always sent first.
   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   // Per-cycle slot request from the sequencer to the shifter.
   typedef struct packed {
      logic load;      // a new slot starts at this bit-clock fall
      logic zero;      // slot belongs to the silent frame
      logic active;    // next bit is part of a frame
   } slot_req_t;

endpackage

// File: rtl/i2s_bclk_gen.sv
module i2s_bclk_gen #(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio,
   output logic               bclk_o,
   output logic               fall_o
);

   localparam int CNT_W = RATIO_W + 1;

   generate
      if (RATIO_W < 1) begin : g_bad_ratio_w
         $error("i2s_bclk_gen: RATIO_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             tick;

   // A half period lasts lim+1 = ratio+2 cycles; >= keeps a lowered ratio safe.
   assign lim  = {1'b0, ratio} + {{(CNT_W-1){1'b0}}, 1'b1};
   assign tick = (cnt >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         bclk_o <= 1'b0;
      end else if (tick) begin
         cnt    <= '0;
         bclk_o <= ~bclk_o;
      end else begin
         cnt    <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      end
   end

   assign fall_o = tick & bclk_o;

   // R1: the shortest half period is two MCLK cycles
   p_min_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bclk_o) |=> $stable(bclk_o));

endmodule

// File: rtl/i2s_tx_seq.sv
module i2s_tx_seq
   import i2s_tx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RES_W  = 6,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             tx_en,
   input  logic [RES_W-1:0] res,
   output slot_req_t        req_o,
   output logic [IDX_W-1:0] nxt_idx_o,
   output logic             active_o,
   output logic             silent_o,
   output logic             ws_o
);

   generate
      if ((1 << RES_W) <= DATA_W) begin : g_bad_res_w
         $error("i2s_tx_seq: RES_W cannot express DATA_W");
      end
   endgenerate

   chan_e            slot, n_slot;
   logic [IDX_W-1:0] idx, n_idx;
   logic [IDX_W-1:0] wm1, n_wm1, wm1_cfg;
   logic             active, n_active;
   logic             silent, n_silent;
   logic             pend, n_pend;
   logic             en_q;
   logic             rise, pend_or, boundary, n_ws;

   // Effective slot length minus one; out-of-range settings fall back to DATA_W.
   always_comb begin
      if (res == '0 || int'(res) > DATA_W) wm1_cfg = IDX_W'(DATA_W - 1);
      else                                 wm1_cfg = IDX_W'(int'(res) - 1);
   end

   assign rise     = tx_en & ~en_q;
   assign pend_or  = pend | rise;
   assign boundary = !active || (slot == CH_RIGHT && idx == '0);

   always_comb begin
      n_active  = active;
      n_slot    = slot;
      n_idx     = idx;
      n_wm1     = wm1;
      n_silent  = silent;
      n_pend    = pend_or;
      req_o     = '0;
      if (fall) begin
         if (boundary) begin
            if (tx_en) begin
               n_active   = 1'b1;
               n_slot     = CH_LEFT;
               n_wm1      = wm1_cfg;
               n_idx      = wm1_cfg;
               n_silent   = pend_or;
               n_pend     = 1'b0;
               req_o.load = 1'b1;
               req_o.zero = pend_or;
            end else begin
               n_active = 1'b0;
               n_slot   = CH_LEFT;
               n_idx    = '0;
               n_silent = 1'b0;
            end
         end else if (idx == '0) begin
            n_slot     = CH_RIGHT;
            n_idx      = wm1;
            req_o.load = 1'b1;
            req_o.zero = silent;
         end else begin
            n_idx = idx - {{(IDX_W-1){1'b0}}, 1'b1};
         end
      end
      req_o.active = n_active;
      // Select leads the slot by one bit: it flips on the LSB of the slot before.
      n_ws = n_active && ((n_slot == CH_RIGHT) ^ (n_idx == '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= CH_LEFT;
         idx    <= '0;
         wm1    <= '0;
         silent <= 1'b0;
         pend   <= 1'b0;
         en_q   <= 1'b0;
         ws_o   <= 1'b0;
      end else begin
         active <= n_active;
         slot   <= n_slot;
         idx    <= n_idx;
         wm1    <= n_wm1;
         silent <= n_silent;
         pend   <= n_pend;
         en_q   <= tx_en;
         ws_o   <= n_ws;
      end
   end

   assign nxt_idx_o = n_idx;
   assign active_o  = active;
   assign silent_o  = silent;

   // R2: the bit index never exceeds the slot length latched for the frame
   p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx <= wm1));

   // R8: a frame is never abandoned in its left slot
   p_no_stop_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && slot == CH_LEFT) |=> active);

endmodule

// File: rtl/i2s_tx_shift.sv
module i2s_tx_shift
   import i2s_tx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  slot_req_t         req,
   input  logic [IDX_W-1:0]  nxt_idx,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              pop_o,
   output logic              underrun_o,
   output logic              sd_o
);

   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] src;
   logic              need;

   assign need       = req.load & ~req.zero;
   assign pop_o      = need & ~fifo_empty;
   assign underrun_o = need & fifo_empty;

   // Silent and starved slots load an all-zero word.
   assign src = req.load ? (pop_o ? fifo_data : '0) : word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word <= '0;
         sd_o <= 1'b0;
      end else if (fall) begin
         if (req.load) word <= src;
         sd_o <= req.active ? src[nxt_idx] : 1'b0;
      end
   end

   // R7: starvation reports last a single MCLK cycle
   p_under_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |=> !underrun_o);

   // R7: a starved slot never pops
   p_under_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> !pop_o);

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
   import i2s_tx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int RATIO_W = 8,
   parameter int RES_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_en,
   input  logic [RATIO_W-1:0] ratio,
   input  logic [RES_W-1:0]   res,
   input  logic [DATA_W-1:0]  fifo_data,
   input  logic               fifo_empty,
   output logic               fifo_pop,
   output logic               bclk,
   output logic               ws,
   output logic               sd,
   output logic               underrun
);

   localparam int IDX_W = $clog2(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2s_tx_serializer: DATA_W must be at least 2");
      end
   endgenerate

   logic             fall;
   slot_req_t        req;
   logic [IDX_W-1:0] nxt_idx;
   logic             active;
   logic             silent;

   i2s_bclk_gen #(
      .RATIO_W (RATIO_W)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .ratio  (ratio),
      .bclk_o (bclk),
      .fall_o (fall)
   );

   i2s_tx_seq #(
      .DATA_W (DATA_W),
      .RES_W  (RES_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (fall),
      .tx_en     (tx_en),
      .res       (res),
      .req_o     (req),
      .nxt_idx_o (nxt_idx),
      .active_o  (active),
      .silent_o  (silent),
      .ws_o      (ws)
   );

   i2s_tx_shift #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall       (fall),
      .req        (req),
      .nxt_idx    (nxt_idx),
      .fifo_data  (fifo_data),
      .fifo_empty (fifo_empty),
      .pop_o      (fifo_pop),
      .underrun_o (underrun),
      .sd_o       (sd)
   );

   // R5: line changes line up with bit-clock falls
   p_lines_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sd) || !$stable(ws)) |-> $fell(bclk));

   // R3: pops coincide with a bit-clock fall
   p_pop_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> $fell(bclk));

   // R6: a popped word never lands in the silent frame
   p_pop_not_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> !silent);

   // R8: outside a frame both lines rest low
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!ws && !sd));

endmodule

// File: tb/tb_i2s_tx_serializer.sv
module tb_i2s_tx_serializer;

   typedef struct packed {
      logic        ch;
      logic        sil;
      logic [31:0] d;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0;
   logic [7:0]  ratio = 8'd0;
   logic [5:0]  res = 6'd32;
   logic [31:0] fifo_data = 32'd0;
   logic        fifo_empty = 1'b1;
   logic        fifo_pop, bclk, ws, sd, underrun;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] fifo_q[$];
   exp_t        exp_q[$];
   int cur_w = 32;
   int prd_skip = 2;
   bit fresh = 1'b1;
   int got_under = 0, exp_under = 0, got_pop = 0, pushed = 0, recv = 0;
   logic last_ch = 1'b1;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2s_tx_serializer dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(ratio), .res(res),
      .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
      .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] lowmask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
   endfunction

   // FIFO model: the design consumes the head word at the edge where pop is high
   initial begin
      forever begin
         @(posedge clk);
         if (fifo_pop && fifo_q.size() > 0) fifo_q.delete(0);
         fifo_empty <= (fifo_q.size() == 0);
         fifo_data  <= (fifo_q.size() > 0) ? fifo_q[0] : 32'd0;
      end
   end

   task automatic word_done(input logic ch, input logic [31:0] d, input int n);
      exp_t e;
      if (fresh) fresh = 1'b0;
      else check(n == cur_w, "R4", "slot length", n, cur_w);
      recv++;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         check(ch == e.ch, "R3", "slot channel", ch, e.ch);
         check(d == e.d, e.sil ? "R6" : "R2", "slot word", d, e.d);
      end else begin
         exp_under++;
         check(ch == !last_ch, "R7", "starved slot channel", ch, !last_ch);
         check(d == 32'd0, "R7", "starved slot word", d, 32'd0);
      end
      last_ch = ch;
   endtask

   // Monitor: decodes the serial stream at bit-clock rises
   initial begin
      logic bclk_q = 1'b0, ws_q = 1'b0, sd_q = 1'b0, wsbit_q = 1'b0;
      logic [31:0] shreg = 32'd0;
      int cyc = 0, last_rise = 0, nbits = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (underrun) got_under++;
            if (fifo_pop) got_pop++;
            if (sd !== sd_q || ws !== ws_q)
               check(bclk_q && !bclk, "R5", "line change off a fall",
                     {30'd0, bclk_q, bclk}, 32'd2);
            if (bclk && !bclk_q) begin
               if (prd_skip > 0) prd_skip--;
               else check(cyc - last_rise == 2 * (int'(ratio) + 2), "R1",
                          "bit clock period", cyc - last_rise, 2 * (int'(ratio) + 2));
               last_rise = cyc;
               shreg = {shreg[30:0], sd};
               nbits++;
               if (ws !== wsbit_q) begin
                  word_done(wsbit_q, shreg & lowmask(cur_w), nbits);
                  nbits = 0;
               end
               wsbit_q = ws;
            end
         end
         bclk_q = bclk; ws_q = ws; sd_q = sd;
      end
   end

   task automatic cfg(input int r, input int s, input int w);
      @(negedge clk);
      ratio = 8'(r);
      res = 6'(s);
      cur_w = w;
      prd_skip = 2;
   endtask

   task automatic start_tx();
      exp_q.push_back('{ch: 1'b0, sil: 1'b1, d: 32'd0});
      exp_q.push_back('{ch: 1'b1, sil: 1'b1, d: 32'd0});
      fresh = 1'b1;
      tx_en = 1'b1;
   endtask

   task automatic push(input logic [31:0] l, input logic [31:0] r);
      fifo_q.push_back(l);
      fifo_q.push_back(r);
      fifo_empty = 1'b0;
      fifo_data = fifo_q[0];
      exp_q.push_back('{ch: 1'b0, sil: 1'b0, d: l & lowmask(cur_w)});
      exp_q.push_back('{ch: 1'b1, sil: 1'b0, d: r & lowmask(cur_w)});
      pushed += 2;
   endtask

   function automatic int frame_cyc();
      return 2 * cur_w * 2 * (int'(ratio) + 2);
   endfunction

   task automatic wait_empty();
      while (fifo_q.size() > 0) @(negedge clk);
   endtask

   task automatic stop_and_settle();
      bit quiet = 1'b1;
      tx_en = 1'b0;
      repeat (2 * frame_cyc() + 16) @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (ws || sd) quiet = 1'b0;
      end
      check(quiet, "R8", "lines low after stop", {30'd0, ws, sd}, 32'd0);
      check(recv % 2 == 0, "R8", "whole frames sent", recv, recv + (recv % 2));
      check(exp_q.size() == 0, "R8", "queued words left", exp_q.size(), 0);
      check(got_pop == pushed, "R3", "pop count", got_pop, pushed);
      check(got_under == exp_under, "R7", "underrun pulses", got_under, exp_under);
   endtask

   initial begin
      int pops_before;
      repeat (3) @(negedge clk);
      check({bclk, ws, sd, fifo_pop, underrun} == 5'd0, "R9", "outputs in reset",
            {27'd0, bclk, ws, sd, fifo_pop, underrun}, 32'd0);
      rst_n = 1'b1;

      // 32-bit slots at the fastest divide, then a starved frame
      cfg(0, 32, 32);
      start_tx();
      push(32'h8123_4567, 32'h0FED_CBA9);
      push(32'hA5A5_0F0F, 32'h5A5A_F0F0);
      push(32'h0000_0001, 32'h8000_0000);
      pops_before = got_pop;
      repeat (frame_cyc() / 2) @(negedge clk);
      check(got_pop == pops_before, "R6", "pops in silent frame", got_pop, pops_before);
      wait_empty();
      repeat (frame_cyc() + frame_cyc() / 2) @(negedge clk);
      stop_and_settle();
      check(exp_under >= 2, "R7", "starved slots seen", exp_under, 2);

      // 16-bit slots, upper word bits must not appear; stop mid-frame
      cfg(2, 16, 16);
      start_tx();
      push(32'hDEAD_1234, 32'hBEEF_8001);
      push(32'h7777_FFFF, 32'h0001_0000);
      wait_empty();
      stop_and_settle();

      // resolution 0 falls back to 32-bit slots
      cfg(1, 0, 32);
      start_tx();
      push(32'hC0DE_0001, 32'h1234_ABCD);
      wait_empty();
      stop_and_settle();

      // resolution above 32 falls back to 32-bit slots
      cfg(0, 40, 32);
      start_tx();
      push(32'h0F0F_F0F0, 32'hFFFF_0000);
      wait_empty();
      stop_and_settle();

      // 24-bit slots with a slower divider
      cfg(3, 24, 24);
      start_tx();
      push(32'hAB80_0001, 32'h127F_FFFE);
      wait_empty();
      stop_and_settle();

      // enable with nothing queued: silent frame then starved frames
      cfg(0, 8, 8);
      start_tx();
      repeat (3 * frame_cyc()) @(negedge clk);
      stop_and_settle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R8 watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule